// File: doc/BRIEF.md
# Execute-Packet Issue Grouper

This block sits at the front of a wide-issue processor whose compiler has already decided which instructions may run together. It accepts one fetch packet of eight 32-bit instruction words and cuts it into execute packets, using one chaining bit carried in every word. The hardware never checks for dependences between instructions. It only follows the compiler's chaining bits.

Each cycle the block presents one execute packet on eight functional-unit slots. The words are packed from slot 0 upward, and each slot has its own valid flag. A downstream stall freezes the packet on the outputs. The block accepts no new fetch packet until the last execute packet of the current one is being issued. A new fetch packet can be accepted in that same cycle, so consecutive fetch packets run with no empty cycle between them.

Top module: `issue_grouper`

## Requirements
- R1: After reset every slot valid flag is 0 and fetchReady is 1.
- R2: Bit 0 of each instruction word is its chaining bit. When the bit is 1, the next word of the packet goes out in the same execute packet.
- R3: A chaining bit of 0 closes the current execute packet, and the next word opens a new execute packet in the following issue cycle.
- R4: Word 7 (bits 255:224 of fetchPacket) always closes its execute packet, whatever its chaining bit. An execute packet never spans two fetch packets.
- R5: The words of an execute packet appear in fetch order on slots 0, 1, 2 and so on. Slot k carries bits 32k+31:32k of slotInstr. Slots beyond the packet show valid 0 and data 0. Word i of the fetch packet is fetchPacket[32i+31:32i].
- R6: fetchReady is 0 while a non-final execute packet of the current fetch packet is pending.
- R7: While downStall is 1 and a packet is presented, the slot outputs hold their values and fetchReady is 0.
- R8: fetchValid has no effect while fetchReady is 0. The execute-packet sequence of the held fetch packet continues unchanged.
- R9: fetchReady is 1 in the cycle the final execute packet issues without stall. A fetch packet offered then shows its first execute packet in the next cycle.
- R10: The chaining bits 0,1,1,0,1,1,0,0 on words 0 to 7 give four issue cycles with slot valid masks 0x01, 0x07, 0x07 and 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchValid | input | 1 | A fetch packet is offered |
| fetchPacket | input | 256 | Eight instruction words, word 0 in the low bits |
| fetchReady | output | 1 | The offered fetch packet is taken at this edge |
| downStall | input | 1 | Downstream cannot take the presented packet |
| slotValid | output | 8 | Valid flag per functional-unit slot |
| slotInstr | output | 256 | Instruction word per slot, slot 0 in the low bits |

## Verification
The bench builds the block with its default parameters: eight slots, 32-bit words and the chaining bit at bit 0. With these values one fetch packet can cover every grouping, from one group of eight to eight groups of one. Directed packets cover the worked example, all-chained and all-broken packets, a stall in mid-packet, offers that must be ignored, and back-to-back packets. Random packets with random stalls and offers are then compared against a grouping model kept in the bench.

// File: rtl/issue_grouper_pkg.sv
package issue_grouper_pkg;
  typedef struct packed {
    logic load;     // capture a new fetch packet, reset cursor
    logic advance;  // presented execute packet issues this cycle
    logic hold;     // a fetch packet is resident
  } grp_ctrl_t;
endpackage

// File: rtl/issue_grouper_dp.sv
module issue_grouper_dp
  import issue_grouper_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int WORD_W    = 32,
  parameter int CHAIN_BIT = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  grp_ctrl_t                     ctrl,
  input  logic [NUM_SLOTS*WORD_W-1:0]   fetchPacket,
  output logic                          isFinal,
  output logic [NUM_SLOTS-1:0]          slotValid,
  output logic [NUM_SLOTS*WORD_W-1:0]   slotInstr
);
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);

  logic [NUM_SLOTS*WORD_W-1:0] pktReg;
  logic [CNT_W-1:0]            headIdx;
  logic [CNT_W-1:0]            groupLen;
  logic [WORD_W-1:0]           words [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_unpack
    assign words[i] = pktReg[i*WORD_W +: WORD_W];
  end

  always_comb begin
    logic chainOn;
    int   idx;
    chainOn   = ctrl.hold;
    slotValid = '0;
    slotInstr = '0;
    groupLen  = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      idx = int'(headIdx) + k;
      if (chainOn && idx < NUM_SLOTS) begin
        slotValid[k]                  = 1'b1;
        slotInstr[k*WORD_W +: WORD_W] = words[idx];
        groupLen                      = groupLen + 1'b1;
        chainOn = words[idx][CHAIN_BIT] && (idx != NUM_SLOTS - 1);
      end else begin
        chainOn = 1'b0;
      end
    end
  end

  assign isFinal = ctrl.hold && ((headIdx + groupLen) == CNT_W'(NUM_SLOTS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktReg  <= '0;
      headIdx <= '0;
    end else if (ctrl.load) begin
      pktReg  <= fetchPacket;
      headIdx <= '0;
    end else if (ctrl.advance) begin
      headIdx <= headIdx + groupLen;
    end
  end

  // R5: valid slots are contiguous from slot 0
  p_packed_slots_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.hold |-> (slotValid[0] && ((slotValid & (slotValid + 1'b1)) == '0)));

  // R4: a group never runs past the end of the fetch packet
  p_end_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.hold |-> (int'(headIdx) + $countones(slotValid) <= NUM_SLOTS));

  // R7: stalled packet stays on the slots
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.hold && !ctrl.advance && !ctrl.load) |=>
      ($stable(slotValid) && $stable(slotInstr)));

  // R2: a slot beyond 0 is filled only when its predecessor chains
  for (genvar k = 1; k < NUM_SLOTS; k++) begin : g_chain_chk
    p_chain_link_r2: assert property (@(posedge clk) disable iff (!rstN)
      slotValid[k] |-> slotInstr[(k-1)*WORD_W + CHAIN_BIT]);
  end
endmodule

// File: rtl/issue_grouper_ctrl.sv
module issue_grouper_ctrl
  import issue_grouper_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fetchValid,
  input  logic      downStall,
  input  logic      isFinal,
  output logic      fetchReady,
  output grp_ctrl_t ctrl
);
  logic busy;

  assign fetchReady   = !busy || (isFinal && !downStall);
  assign ctrl.hold    = busy;
  assign ctrl.advance = busy && !downStall;
  assign ctrl.load    = fetchValid && fetchReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      busy <= 1'b0;
    else if (ctrl.load)             busy <= 1'b1;
    else if (ctrl.advance && isFinal) busy <= 1'b0;
  end

  // R6: no new fetch packet while non-final groups remain
  p_midpkt_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !isFinal) |-> !fetchReady);

  // R7: stall while holding blocks fetch
  p_stall_noready_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && downStall) |-> !fetchReady);

  // R9: final group issued with no new packet leaves the block idle
  p_final_drain_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !downStall && isFinal && !fetchValid) |=> !busy);

  // R8: a held packet is not dropped while blocked
  p_keep_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !fetchReady) |=> busy);
endmodule

// File: rtl/issue_grouper.sv
module issue_grouper
  import issue_grouper_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int WORD_W    = 32,
  parameter int CHAIN_BIT = 0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        fetchValid,
  input  logic [NUM_SLOTS*WORD_W-1:0] fetchPacket,
  output logic                        fetchReady,
  input  logic                        downStall,
  output logic [NUM_SLOTS-1:0]        slotValid,
  output logic [NUM_SLOTS*WORD_W-1:0] slotInstr
);
  grp_ctrl_t ctrl;
  logic      isFinal;

  issue_grouper_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .downStall(downStall),
    .isFinal(isFinal), .fetchReady(fetchReady), .ctrl(ctrl)
  );

  issue_grouper_dp #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .CHAIN_BIT(CHAIN_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .fetchPacket(fetchPacket),
    .isFinal(isFinal), .slotValid(slotValid), .slotInstr(slotInstr)
  );
endmodule

// File: tb/issue_grouper_bench.sv
module issue_grouper_bench;
  localparam int N = 8;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           fetchValid = 1'b0;
  logic [N*W-1:0] fetchPacket = '0;
  logic           fetchReady;
  logic           downStall = 1'b0;
  logic [N-1:0]   slotValid;
  logic [N*W-1:0] slotInstr;

  int nTests = 0;
  int nFail  = 0;
  int cycles = 0;

  // model state
  bit             mBusy = 0;
  logic [N*W-1:0] mPkt  = '0;
  int             mHead = 0;

  always #5 clk = ~clk;

  issue_grouper u_issue_grouper (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPacket(fetchPacket),
    .fetchReady(fetchReady), .downStall(downStall),
    .slotValid(slotValid), .slotInstr(slotInstr)
  );

  function automatic int grpLen(logic [N*W-1:0] p, int head);
    int n = 1;
    while (head + n - 1 < N - 1 && p[(head + n - 1)*W] == 1'b1) n++;
    return n;
  endfunction

  // build a packet: word i = {tag, i, pad, flag}
  function automatic logic [N*W-1:0] mkPkt(logic [7:0] flags, logic [7:0] tag);
    logic [N*W-1:0] p;
    for (int i = 0; i < N; i++)
      p[i*W +: W] = {tag, 8'(i), 15'h1234, 1'b0} | W'(flags[i]);
    return p;
  endfunction

  task automatic chk(input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive, sample, compare against model, advance model
  task automatic step(input bit fv, input logic [N*W-1:0] pkt, input bit st,
                      input string tag, input int expMask = -1);
    int             len;
    bit             fin, expRdy;
    logic [N-1:0]   eVal;
    logic [N*W-1:0] eIns;
    @(negedge clk);
    fetchValid  = fv;
    fetchPacket = pkt;
    downStall   = st;
    #1;
    eVal = '0; eIns = '0; len = 0; fin = 0;
    if (mBusy) begin
      len = grpLen(mPkt, mHead);
      for (int k = 0; k < len; k++) begin
        eVal[k] = 1'b1;
        eIns[k*W +: W] = mPkt[(mHead + k)*W +: W];
      end
      fin = (mHead + len == N);
    end
    expRdy = !mBusy || (fin && !st);
    chk({tag, " slotValid"}, N*W'(slotValid), N*W'(eVal));
    chk({tag, " slotInstr"}, slotInstr, eIns);
    chk({tag, " fetchReady"}, N*W'(fetchReady), N*W'(expRdy));
    if (expMask >= 0) chk({tag, " mask"}, N*W'(slotValid), N*W'(expMask));
    if (mBusy && !st) begin
      mHead += len;
      if (fin) mBusy = 0;
    end
    if (fv && expRdy) begin
      mBusy = 1; mPkt = pkt; mHead = 0;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] p, q;
    process::self().srandom(32'd7741);
    #12;
    // R1: reset state
    chk("R1 slotValid", N*W'(slotValid), '0);
    chk("R1 fetchReady", N*W'(fetchReady), N*W'(1));
    @(negedge clk); rstN = 1'b1;

    // R10: worked example
    p = mkPkt(8'b0011_0110, 8'hA1);
    step(1, p, 0, "R10");
    step(0, '0, 0, "R10", 8'h01);
    step(0, '0, 0, "R10", 8'h07);
    step(0, '0, 0, "R10", 8'h07);
    step(0, '0, 0, "R10", 8'h01);
    step(0, '0, 0, "R1 idle", 8'h00);

    // R4: all chained, word 7 flag 1 still closes
    p = mkPkt(8'hFF, 8'hB2);
    step(1, p, 0, "R4");
    step(0, '0, 0, "R4", 8'hFF);
    step(0, '0, 0, "R4 idle", 8'h00);

    // R3: no chaining, eight single groups
    p = mkPkt(8'h00, 8'hC3);
    step(1, p, 0, "R3");
    for (int i = 0; i < N; i++) step(0, '0, 0, "R3", 8'h01);

    // R7 stall, R8 ignored offer, R6 blocking
    p = mkPkt(8'b0101_0101, 8'hD4);
    q = mkPkt(8'hFF, 8'hEE);
    step(1, p, 0, "R7");
    step(0, '0, 1, "R7", 8'h03);
    step(1, q, 1, "R7", 8'h03);
    step(1, q, 0, "R8", 8'h03);
    step(1, q, 0, "R6", 8'h03);
    step(1, q, 0, "R8", 8'h03);
    // R9: final group issues while q is offered, q follows with no bubble
    step(1, q, 0, "R9", 8'h03);
    step(0, '0, 0, "R9", 8'hFF);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      for (int j = 0; j < N; j++) p[j*W +: W] = $urandom;
      step(($urandom % 10) < 7, p, ($urandom % 4) == 0, "R5");
    end
    for (int i = 0; i < 20; i++) step(0, '0, 0, "R5");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule